// File: doc/BRIEF.md
# Host Bridge Configuration Register Space

This block holds the function-0 configuration bytes of a PCI host bridge. Software reaches it through a byte-wide port that carries a function number, an 8-bit offset and a data byte. A write is a single-cycle strobe. A read returns its byte on a registered output one cycle later. The block loads fixed identification and DRAM-setup values at reset. It protects read-only ranges, lets only one bit of the command byte change, and treats three status bits as write-one-to-clear.

Three of the bytes control shadow RAM for the legacy region from 0xC0000 to 0xFFFFF. Each 2-bit field routes the reads and writes of one segment either to internal DRAM or to the external bus. Bytes 0x61 and 0x62 cover eight 16 KB segments. Byte 0x63 covers two 64 KB segments. A combinational query port takes a memory address and reports where reads and where writes to that address go. A flag output shows whether the BIOS area is being read from DRAM. A soft-reset pulse switches BIOS shadowing off and leaves all other state alone.

Top module: `hb_cfg_space`

## Requirements
- R1: After `rst`, the bytes read through function 0 are as follows, and every other offset reads 0x00:

  | Offset | Value |
  |---|---|
  | 0x00 | 0x06 |
  | 0x01 | 0x11 |
  | 0x02 | 0x85 |
  | 0x03 | 0x05 |
  | 0x04 | 0x07 |
  | 0x06 | 0xA0 |
  | 0x07 | 0x02 |
  | 0x0B | 0x06 |
  | 0x58 | 0x40 |
  | 0x59 | 0x05 |
  | 0x5A to 0x5F | 0x01 each |
  | 0x64 | 0xAB |

  Also after `rst`, `cfg_rdata` is 0x00 and `bios_shadowed` is 0.
- R2: A write to any of these offsets leaves the stored byte unchanged: 0x00–0x03, 0x05–0x06, 0x08–0x0C, 0x0E–0x11, 0x14–0x4F, 0x79–0x7D, 0x85–0x87, 0x8C–0xA7, 0xAD–0xFC.
- R3: A write to offset 0x04 changes only bit 6, which takes the written value. Bits 7 and 5:0 keep their value.
- R4: A write to offset 0x07 clears each of bits 7, 5 and 4 where the written data has a 1, and leaves it where the data has a 0. It never sets a bit, and bits 6 and 3:0 are unaffected (bit 1 stays 1).
- R5: Every offset not named in R2, R3 or R4 is plain read/write storage, for example 0x0D, 0x12, 0x50, 0x7E, 0x88, 0xA8 and 0xFD.
- R6: Each 2-bit shadow field routes its segment as follows:

  | Field | Reads | Writes |
  |---|---|---|
  | 0 | external bus | external bus |
  | 1 | external bus | DRAM |
  | 2 | DRAM | external bus |
  | 3 | DRAM | DRAM |

  `route_rd_dram` and `route_wr_dram` are 1 for DRAM and 0 for the external bus.
- R7: Offset 0x61 bits [1:0], [3:2], [5:4] and [7:6] control the 16 KB segments at 0xC0000, 0xC4000, 0xC8000 and 0xCC000. Offset 0x62 bits [1:0], [3:2], [5:4] and [7:6] control 0xD0000, 0xD4000, 0xD8000 and 0xDC000.
- R8: Offset 0x63 bits [7:6] control the 64 KB segment at 0xE0000, and bits [5:4] control the 64 KB segment at 0xF0000. `bios_shadowed` equals bit 5 of offset 0x63.
- R9: A `soft_rst` pulse clears bits [5:4] of offset 0x63 and preserves all other bits and bytes. If a write to 0x63 happens in the same cycle, the written byte is stored with bits [5:4] forced to 0.
- R10: A read with `cfg_func` other than 0 returns 0xFF. A write with `cfg_func` other than 0 changes nothing.
- R11: A query address below 0xC0000 reports both reads and writes as going to DRAM, whatever the shadow bytes hold.
- R12: `cfg_rdata` takes the addressed byte at the clock edge where `cfg_rd` is high and holds it while `cfg_rd` is low. If a read and a write to the same offset happen in the same cycle, the read returns the value before the write. The routing outputs reflect a shadow-byte write from the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Soft reset pulse that disables BIOS shadowing |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_func | input | FUNC_W | Function number of the access |
| cfg_off | input | 8 | Register offset |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Registered read data |
| route_addr | input | ADDR_W | Memory address for the routing query |
| route_rd_dram | output | 1 | Reads of route_addr go to DRAM |
| route_wr_dram | output | 1 | Writes of route_addr go to DRAM |
| bios_shadowed | output | 1 | BIOS area is read from DRAM |

## Verification
The hardest situation to reach is a soft reset that lands in the same cycle as a configuration write to the shadow byte at 0x63. The bench drives both strobes in one cycle with data that sets the bits the reset must clear, then reads the byte back. The status clear bits are all zero after reset and cannot be set through the port. They are therefore checked by showing that writing all ones and all zeros leaves the byte at its reset value. Each routing field is given a distinct code, with the order reversed between 0x61 and 0x62, so that a mix-up of segment index or bit order shows up at a specific query address.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

    localparam int CFG_BYTES = 256;
    localparam int OFF_W     = $clog2(CFG_BYTES);
    localparam int BYTE_W    = 8;

    localparam logic [OFF_W-1:0] OFF_CMD    = 8'h04;
    localparam logic [OFF_W-1:0] OFF_STS_HI = 8'h07;
    localparam logic [OFF_W-1:0] OFF_SHD_C  = 8'h61;
    localparam logic [OFF_W-1:0] OFF_SHD_D  = 8'h62;
    localparam logic [OFF_W-1:0] OFF_SHD_EF = 8'h63;

    localparam logic [BYTE_W-1:0] CMD_WMASK = 8'h40;
    localparam logic [BYTE_W-1:0] STS_W1C   = 8'hB0;
    localparam logic [BYTE_W-1:0] SOFT_CLR  = 8'h30;
    localparam logic [BYTE_W-1:0] NO_FUNC   = 8'hFF;

    localparam int SEG16_COUNT = 8;
    localparam int FIELD_W     = 2;

    typedef enum logic [1:0] {
        SHD_EXT      = 2'd0,
        SHD_WR_DRAM  = 2'd1,
        SHD_RD_DRAM  = 2'd2,
        SHD_ALL_DRAM = 2'd3
    } shd_mode_e;

    typedef struct packed {
        logic rd_dram;
        logic wr_dram;
    } route_t;

    typedef enum logic [1:0] {
        WP_IGNORE,
        WP_MASKED,
        WP_CLEAR1,
        WP_PLAIN
    } wpol_e;

    function automatic route_t mode_to_route(shd_mode_e m);
        route_t r;
        unique case (m)
            SHD_EXT:      r = '{rd_dram: 1'b0, wr_dram: 1'b0};
            SHD_WR_DRAM:  r = '{rd_dram: 1'b0, wr_dram: 1'b1};
            SHD_RD_DRAM:  r = '{rd_dram: 1'b1, wr_dram: 1'b0};
            default:      r = '{rd_dram: 1'b1, wr_dram: 1'b1};
        endcase
        return r;
    endfunction

    function automatic logic is_read_only(logic [OFF_W-1:0] off);
        return off inside {[8'h00:8'h03], [8'h05:8'h06], [8'h08:8'h0C],
                           [8'h0E:8'h11], [8'h14:8'h4F], [8'h79:8'h7D],
                           [8'h85:8'h87], [8'h8C:8'hA7], [8'hAD:8'hFC]};
    endfunction

    function automatic wpol_e write_policy(logic [OFF_W-1:0] off);
        if (is_read_only(off))       return WP_IGNORE;
        else if (off == OFF_CMD)     return WP_MASKED;
        else if (off == OFF_STS_HI)  return WP_CLEAR1;
        else                         return WP_PLAIN;
    endfunction

    function automatic logic [BYTE_W-1:0] reset_byte(logic [OFF_W-1:0] off);
        logic [BYTE_W-1:0] v;
        case (off)
            8'h00: v = 8'h06;
            8'h01: v = 8'h11;
            8'h02: v = 8'h85;
            8'h03: v = 8'h05;
            8'h04: v = 8'h07;
            8'h06: v = 8'hA0;
            8'h07: v = 8'h02;
            8'h0B: v = 8'h06;
            8'h58: v = 8'h40;
            8'h59: v = 8'h05;
            8'h5A, 8'h5B, 8'h5C,
            8'h5D, 8'h5E, 8'h5F: v = 8'h01;
            8'h64: v = 8'hAB;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/hb_cfg_merge.sv
module hb_cfg_merge
    import hb_cfg_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0] wdata,
    output logic              upd,
    output logic [BYTE_W-1:0] nxt
);
    wpol_e pol;

    always_comb begin
        pol = write_policy(off);
        upd = (pol != WP_IGNORE);
        unique case (pol)
            WP_MASKED: nxt = (cur & ~CMD_WMASK) | (wdata & CMD_WMASK);
            WP_CLEAR1: nxt = cur & ~(wdata & STS_W1C);
            WP_PLAIN:  nxt = wdata;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/hb_cfg_store.sv
module hb_cfg_store
    import hb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cur_byte,
    output logic [BYTE_W-1:0] shd_c,
    output logic [BYTE_W-1:0] shd_d,
    output logic [BYTE_W-1:0] shd_ef
);
    logic [BYTE_W-1:0] mem [CFG_BYTES];
    logic              upd;
    logic [BYTE_W-1:0] nxt;
    logic              do_wr;
    logic [BYTE_W-1:0] ef_next;

    assign cur_byte = mem[off];
    assign shd_c    = mem[OFF_SHD_C];
    assign shd_d    = mem[OFF_SHD_D];
    assign shd_ef   = mem[OFF_SHD_EF];

    hb_cfg_merge u_merge (
        .off   (off),
        .cur   (cur_byte),
        .wdata (wdata),
        .upd   (upd),
        .nxt   (nxt)
    );

    assign do_wr   = wr_en && upd;
    assign ef_next = ((do_wr && off == OFF_SHD_EF) ? nxt : mem[OFF_SHD_EF]) & ~SOFT_CLR;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++) begin
                mem[i] <= reset_byte(OFF_W'(i));
            end
        end else begin
            if (do_wr) begin
                mem[off] <= nxt;
            end
            if (soft_rst) begin
                mem[OFF_SHD_EF] <= ef_next;
            end
        end
    end

    // R2: protected bytes never change on a write
    p_ro_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_read_only(off)) |=> (mem[$past(off)] == $past(cur_byte)));

    // R3: command byte changes only in its writable bit
    p_cmd_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_CMD && !soft_rst) |=>
        (((mem[OFF_CMD] ^ $past(mem[OFF_CMD])) & ~CMD_WMASK) == '0) &&
        (mem[OFF_CMD][6] == $past(wdata[6])));

    // R4: status write never sets a bit and only touches clearable bits
    p_sts_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_STS_HI) |=>
        ((mem[OFF_STS_HI] & ~$past(mem[OFF_STS_HI])) == '0) &&
        (((mem[OFF_STS_HI] ^ $past(mem[OFF_STS_HI])) & ~STS_W1C) == '0));

    // R9: soft reset leaves the BIOS shadow field at zero
    p_soft_clr_r9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> ((mem[OFF_SHD_EF] & SOFT_CLR) == '0));
endmodule

// File: rtl/hb_shadow_route.sv
module hb_shadow_route
    import hb_cfg_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] shd_c,
    input  logic [BYTE_W-1:0] shd_d,
    input  logic [3:0]        shd_ef_hi,
    output route_t            route
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(20'hC0000);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(20'hFFFFF);
    localparam int SEG_IDX_W = $clog2(SEG16_COUNT);

    logic [2*BYTE_W-1:0] shd_cd;
    route_t              seg16 [SEG16_COUNT];
    route_t              seg_e;
    route_t              seg_f;
    logic                in_win;
    logic [SEG_IDX_W-1:0] idx16;

    assign shd_cd = {shd_d, shd_c};

    for (genvar g = 0; g < SEG16_COUNT; g++) begin : g_seg16
        assign seg16[g] = mode_to_route(shd_mode_e'(shd_cd[FIELD_W*g +: FIELD_W]));
    end

    assign seg_f  = mode_to_route(shd_mode_e'(shd_ef_hi[1:0]));
    assign seg_e  = mode_to_route(shd_mode_e'(shd_ef_hi[3:2]));
    assign in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
    assign idx16  = addr[16:14];

    always_comb begin
        if (!in_win)        route = '{rd_dram: 1'b1, wr_dram: 1'b1};
        else if (!addr[17]) route = seg16[idx16];
        else if (addr[16])  route = seg_f;
        else                route = seg_e;
    end
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
    import hb_cfg_pkg::*;
#(
    parameter int FUNC_W = 3,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] route_addr,
    output logic              route_rd_dram,
    output logic              route_wr_dram,
    output logic              bios_shadowed
);
    logic              fn0;
    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] shd_c;
    logic [BYTE_W-1:0] shd_d;
    logic [BYTE_W-1:0] shd_ef;
    route_t            route;

    assign fn0 = (cfg_func == '0);

    hb_cfg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (cfg_wr && fn0),
        .off      (cfg_off),
        .wdata    (cfg_wdata),
        .cur_byte (cur_byte),
        .shd_c    (shd_c),
        .shd_d    (shd_d),
        .shd_ef   (shd_ef)
    );

    hb_shadow_route #(.ADDR_W(ADDR_W)) u_route (
        .addr      (route_addr),
        .shd_c     (shd_c),
        .shd_d     (shd_d),
        .shd_ef_hi (shd_ef[7:4]),
        .route     (route)
    );

    assign route_rd_dram = route.rd_dram;
    assign route_wr_dram = route.wr_dram;
    assign bios_shadowed = shd_ef[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= fn0 ? cur_byte : NO_FUNC;
        end
    end

    // R10: other functions read as all ones
    p_other_func_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && !fn0) |=> (cfg_rdata == NO_FUNC));

    // R12: read data holds between read strobes
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> $stable(cfg_rdata));

    // R11: addresses below the shadow window always use DRAM
    p_low_dram_r11: assert property (@(posedge clk) disable iff (rst)
        (route_addr < ADDR_W'(20'hC0000)) |-> (route_rd_dram && route_wr_dram));

    // R8: BIOS flag agrees with read routing of the top segment
    p_bios_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (route_addr >= ADDR_W'(20'hF0000) && route_addr <= ADDR_W'(20'hFFFFF))
        |-> (route_rd_dram == bios_shadowed));
endmodule

// File: tb/hb_cfg_space_bench.sv
module hb_cfg_space_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_off = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [19:0] route_addr = '0;
    logic        route_rd_dram;
    logic        route_wr_dram;
    logic        bios_shadowed;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_cfg_space u_hb_cfg_space (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_func(cfg_func),
        .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .route_addr(route_addr), .route_rd_dram(route_rd_dram),
        .route_wr_dram(route_wr_dram), .bios_shadowed(bios_shadowed)
    );

    function automatic logic [7:0] exp_reset(int off);
        case (off)
            'h00: return 8'h06;  'h01: return 8'h11;
            'h02: return 8'h85;  'h03: return 8'h05;
            'h04: return 8'h07;  'h06: return 8'hA0;
            'h07: return 8'h02;  'h0B: return 8'h06;
            'h58: return 8'h40;  'h59: return 8'h05;
            'h64: return 8'hAB;
            default: return (off >= 'h5A && off <= 'h5F) ? 8'h01 : 8'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] f, logic [7:0] off, logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_func = f; cfg_off = off; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_func = '0;
    endtask

    task automatic rd(logic [2:0] f, logic [7:0] off, output logic [7:0] v);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_func = f; cfg_off = off;
        @(negedge clk);
        cfg_rd = 1'b0; cfg_func = '0;
        v = cfg_rdata;
    endtask

    task automatic chk_byte(string req, logic [7:0] off, logic [7:0] exp);
        logic [7:0] v;
        rd(3'd0, off, v);
        chk(req, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic chk_route(string req, logic [19:0] a, logic er, logic ew);
        route_addr = a;
        #1;
        chk(req, {30'h0, route_rd_dram, route_wr_dram}, {30'h0, er, ew});
    endtask

    task automatic t_reset();
        chk("R1 rdata after reset", {24'h0, cfg_rdata}, 32'h0);
        chk("R1 bios flag after reset", {31'h0, bios_shadowed}, 32'h0);
        for (int i = 0; i < 256; i++) begin
            chk_byte("R1 reset byte", 8'(i), exp_reset(i));
        end
    endtask

    task automatic t_readonly();
        logic [7:0] ro [12] = '{8'h00, 8'h03, 8'h05, 8'h06, 8'h08, 8'h0E,
                                8'h14, 8'h4F, 8'h79, 8'h85, 8'h8C, 8'hAD};
        foreach (ro[i]) begin
            wr(3'd0, ro[i], 8'h5A);
            chk_byte("R2 read-only kept", ro[i], exp_reset(int'(ro[i])));
        end
        wr(3'd0, 8'hFC, 8'h77);
        chk_byte("R2 read-only 0xFC", 8'hFC, 8'h00);
    endtask

    task automatic t_plain();
        logic [7:0] rw [7] = '{8'h0D, 8'h12, 8'h50, 8'h7E, 8'h88, 8'hA8, 8'hFD};
        foreach (rw[i]) begin
            wr(3'd0, rw[i], 8'hC3 ^ rw[i]);
            chk_byte("R5 plain storage", rw[i], 8'hC3 ^ rw[i]);
        end
    endtask

    task automatic t_command();
        wr(3'd0, 8'h04, 8'h40);
        chk_byte("R3 cmd set bit6", 8'h04, 8'h47);
        wr(3'd0, 8'h04, 8'hB8);
        chk_byte("R3 cmd clear bit6 keep rest", 8'h04, 8'h07);
        wr(3'd0, 8'h04, 8'hFF);
        chk_byte("R3 cmd all ones", 8'h04, 8'h47);
        wr(3'd0, 8'h04, 8'h00);
    endtask

    task automatic t_status();
        wr(3'd0, 8'h07, 8'hFF);
        chk_byte("R4 status w1c all ones", 8'h07, 8'h02);
        wr(3'd0, 8'h07, 8'h00);
        chk_byte("R4 status zero write", 8'h07, 8'h02);
    endtask

    task automatic t_shadow();
        chk_route("R6 field 0 at C0000 after reset", 20'hC0000, 1'b0, 1'b0);
        wr(3'd0, 8'h61, 8'hE4);
        chk_route("R7 C0000 mode0", 20'hC0000, 1'b0, 1'b0);
        chk_route("R7 C4000 mode1", 20'hC4000, 1'b0, 1'b1);
        chk_route("R7 C8000 mode2", 20'hC8000, 1'b1, 1'b0);
        chk_route("R7 CC000 mode3", 20'hCC000, 1'b1, 1'b1);
        chk_route("R7 CFFFF mode3", 20'hCFFFF, 1'b1, 1'b1);
        wr(3'd0, 8'h62, 8'h1B);
        chk_route("R7 D0000 mode3", 20'hD0000, 1'b1, 1'b1);
        chk_route("R6 D4000 mode2", 20'hD4000, 1'b1, 1'b0);
        chk_route("R6 D8000 mode1", 20'hD8000, 1'b0, 1'b1);
        chk_route("R7 DFFFF mode0", 20'hDFFFF, 1'b0, 1'b0);
        wr(3'd0, 8'h63, 8'h60);
        chk_route("R8 E0000 mode1", 20'hE0000, 1'b0, 1'b1);
        chk_route("R8 F0000 mode2", 20'hF0000, 1'b1, 1'b0);
        chk("R8 bios flag set", {31'h0, bios_shadowed}, 32'h1);
        wr(3'd0, 8'h63, 8'h90);
        chk_route("R8 EFFFF mode2", 20'hEFFFF, 1'b1, 1'b0);
        chk_route("R8 FFFFF mode1", 20'hFFFFF, 1'b0, 1'b1);
        chk("R8 bios flag clear", {31'h0, bios_shadowed}, 32'h0);
        chk_route("R11 address 0", 20'h00000, 1'b1, 1'b1);
        chk_route("R11 address BFFFF", 20'hBFFFF, 1'b1, 1'b1);
    endtask

    task automatic t_soft_reset();
        wr(3'd0, 8'h63, 8'hFF);
        chk("R8 bios flag before soft reset", {31'h0, bios_shadowed}, 32'h1);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R9 bios flag after soft reset", {31'h0, bios_shadowed}, 32'h0);
        chk_byte("R9 soft reset keeps other bits", 8'h63, 8'hCF);
        chk_byte("R9 soft reset leaves 0x61", 8'h61, 8'hE4);
        @(negedge clk);
        soft_rst = 1'b1; cfg_wr = 1'b1; cfg_off = 8'h63; cfg_wdata = 8'h3F;
        @(negedge clk);
        soft_rst = 1'b0; cfg_wr = 1'b0;
        chk_byte("R9 soft reset wins over write", 8'h63, 8'h0F);
    endtask

    task automatic t_func();
        logic [7:0] v;
        rd(3'd1, 8'h00, v);
        chk("R10 read func1", {24'h0, v}, 32'hFF);
        rd(3'd7, 8'h64, v);
        chk("R10 read func7", {24'h0, v}, 32'hFF);
        wr(3'd2, 8'h50, 8'h99);
        chk_byte("R10 write func2 ignored", 8'h50, 8'hC3 ^ 8'h50);
        wr(3'd3, 8'h61, 8'hFF);
        chk_route("R10 write func3 no route change", 20'hC0000, 1'b0, 1'b0);
    endtask

    task automatic t_timing();
        logic [7:0] v;
        wr(3'd0, 8'h50, 8'h11);
        rd(3'd0, 8'h50, v);
        repeat (3) @(negedge clk);
        chk("R12 rdata holds while idle", {24'h0, cfg_rdata}, 32'h11);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_off = 8'h50; cfg_wdata = 8'h22;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
        chk("R12 same-cycle read returns old", {24'h0, cfg_rdata}, 32'h11);
        chk_byte("R12 write landed", 8'h50, 8'h22);
        wr(3'd0, 8'h61, 8'h00);
        route_addr = 20'hC0000;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = 8'h61; cfg_wdata = 8'h03;
        #1;
        chk("R12 route before write edge", {30'h0, route_rd_dram, route_wr_dram}, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R12 route after write edge", {30'h0, route_rd_dram, route_wr_dram}, 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readonly();
        t_plain();
        t_command();
        t_status();
        t_shadow();
        t_soft_reset();
        t_func();
        t_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule